// File: doc/BRIEF.md
# Invertible Trigger Conditioner with Hold Time

This stage sits between a raw external trigger line and the start input of a waveform generator. It can flip the polarity of the incoming line and then looks for a rising edge of the result. A qualifying edge raises the conditioned output for a programmable number of clocks. During that time, contact bounce and repeated triggers are swallowed.

When the hold time ends, the stage does one of two things, chosen by the rearm-enable input:
- With rearm enabled, it returns to the armed state by itself.
- With rearm disabled, it stays spent until the host pulses the disarm input.

While disarm is high, the stage is held inert and its output is low. After the chip-level reset, the stage is disarmed. It arms itself one clock after disarm is low.

Top module: `trig_conditioner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stage returns to the disarmed state. `trig_out` is low in the cycle after that edge.
- R2: The detected signal is `trig_in XOR invert`. With `invert` = 1, a falling edge of `trig_in` fires the stage. With `invert` = 1, a rising edge of `trig_in` does not fire it.
- R3: Suppose a rising edge of the detected signal is sampled at clock edge k while the stage is armed. Then `trig_out` goes high right after edge k.
- R4: For a count N ≥ 1, `trig_out` stays high for exactly N clock cycles. N is the `hold_count` value sampled at the firing edge. Later changes of `hold_count` do not change the length of a pulse that is already running.
- R5: A `hold_count` of zero gives an output pulse of exactly one clock cycle.
- R6: Rising edges of the detected signal that arrive while `trig_out` is high are ignored. They neither extend nor restart the pulse.
- R7: If `auto_rearm` is 1 in the last cycle of a pulse, the stage is armed right after the pulse. The next new rising edge fires it again.
- R8: If `auto_rearm` is 0 in the last cycle of a pulse, the stage becomes spent. Every later edge is ignored until `disarm` has been high for at least one clock edge.
- R9: When `disarm` is high at a clock edge, `trig_out` is low after that edge, and any running pulse is aborted. The stage arms one cycle after `disarm` falls. A detected level that is already high when disarm is released is not an edge.
- R10: All 64 bits of `hold_count` take part in the hold length. A count with only bit 32 set keeps `trig_out` high far beyond 2^32 cycles' worth of low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disarm | input | 1 | Holds the stage disarmed with output low; a pulse rearms a spent stage |
| trig_in | input | 1 | Raw trigger, already synchronised to `clk` |
| invert | input | 1 | 1 = detect falling edges of `trig_in` |
| auto_rearm | input | 1 | 1 = rearm by itself after the hold |
| hold_count | input | HOLD_W (64) | Output pulse length in clocks (0 acts as 1) |
| trig_out | output | 1 | Conditioned trigger |

## Verification
The bench builds the block with its default 64-bit hold count.

Random counts are kept between 0 and 9. This puts zero-length and one-cycle pulses, retriggers inside the hold, and rearm at the exact closing cycle within a few thousand clocks. Toggles of polarity, of the rearm mode and of disarm are mixed in at random.

One directed case loads a count with only bit 32 set. It watches the output stay high for hundreds of cycles and then aborts the pulse with disarm. This reaches the upper word without waiting out the count.

// File: rtl/trig_cond_pkg.sv
// Shared types for the trigger conditioner.
package trig_cond_pkg;

    // Conditioner states: inert, waiting for an edge, pulse running, used up.
    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_HOLD     = 2'd2,
        ST_SPENT    = 2'd3
    } tc_state_t;

endpackage

// File: rtl/trig_edge_detect.sv
// Polarity select and rising-edge detection of the trigger line.
// Assumes trig_in is already synchronous to clk. After reset the previous
// value reads as high, so a line that is high out of reset is not an edge.
module trig_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic invert,
    output logic edge_seen
);

    logic level;
    logic level_q;

    assign level     = trig_in ^ invert;
    assign edge_seen = level & ~level_q;

    // Remember the detected level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b1;
        end else begin
            level_q <= level;
        end
    end

    // Two edges in a row are impossible: an edge leaves the level high.
    assert_no_double_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> !edge_seen);

endmodule

// File: rtl/trig_hold_timer.sv
// Down-counter that times the output pulse. A load of value N gives N
// cycles of run before done (N = 0 behaves as 1). Clear has priority.
module trig_hold_timer #(
    parameter int HOLD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              run,
    output logic              done
);

    localparam logic [HOLD_W-1:0] ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

    logic [HOLD_W-1:0] remain;

    assign done = (remain == '0);

    // Load the remaining-cycle count, then step it down while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            remain <= '0;
        end else if (load) begin
            remain <= (load_val == '0) ? '0 : load_val - ONE;
        end else if (run && !done) begin
            remain <= remain - ONE;
        end
    end

    // A zero or one count finishes in the first running cycle.
    assert_short_count_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr && load_val <= ONE) |=> done);

endmodule

// File: rtl/trig_conditioner.sv
// Trigger conditioner: optional inversion, rising-edge detection, output
// held for a programmable count, then automatic or host-driven rearm.
// Assumes all inputs are synchronous to clk; disarm is level sensitive.
module trig_conditioner #(
    parameter int HOLD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disarm,
    input  logic              trig_in,
    input  logic              invert,
    input  logic              auto_rearm,
    input  logic [HOLD_W-1:0] hold_count,
    output logic              trig_out
);

    import trig_cond_pkg::*;

    tc_state_t state;
    logic      edge_seen;
    logic      fire;
    logic      hold_done;

    trig_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .invert    (invert),
        .edge_seen (edge_seen)
    );

    assign fire = (state == ST_ARMED) && edge_seen && !disarm;

    trig_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (disarm),
        .load     (fire),
        .load_val (hold_count),
        .run      (state == ST_HOLD),
        .done     (hold_done)
    );

    // Sequence the stage through disarmed, armed, holding and spent.
    always_ff @(posedge clk) begin
        if (!rst_n || disarm) begin
            state <= ST_DISARMED;
        end else begin
            unique case (state)
                ST_DISARMED: state <= ST_ARMED;
                ST_ARMED:    if (edge_seen) state <= ST_HOLD;
                ST_HOLD:     if (hold_done) state <= auto_rearm ? ST_ARMED : ST_SPENT;
                ST_SPENT:    state <= ST_SPENT;
                default:     state <= ST_DISARMED;
            endcase
        end
    end

    assign trig_out = (state == ST_HOLD);

    assert_disarm_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !trig_out);

    assert_fire_needs_armed_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> ($past(state) == ST_ARMED) && $past(edge_seen));

    assert_hold_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !hold_done && !disarm) |=> trig_out);

    assert_spent_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPENT && !disarm) |=> (state == ST_SPENT));

    assert_auto_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_done && auto_rearm && !disarm) |=> (state == ST_ARMED));

endmodule

// File: tb/trig_conditioner_tb_top.sv
module trig_conditioner_tb_top;

    localparam int HOLD_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              disarm = 1'b1;
    logic              trig_in = 1'b0;
    logic              invert = 1'b0;
    logic              auto_rearm = 1'b0;
    logic [HOLD_W-1:0] hold_count = '0;
    logic              trig_out;

    int errors = 0;
    int checks = 0;

    // Reference model state: 0 disarmed, 1 armed, 2 holding, 3 spent.
    int          m_mode = 0;
    logic [HOLD_W-1:0] m_left = '0;
    logic        m_prev = 1'b1;
    logic        exp_out = 1'b0;

    always #10 clk = ~clk;

    trig_conditioner #(.HOLD_W(HOLD_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .disarm     (disarm),
        .trig_in    (trig_in),
        .invert     (invert),
        .auto_rearm (auto_rearm),
        .hold_count (hold_count),
        .trig_out   (trig_out)
    );

    // Advance the requirement model by one clock edge using current inputs.
    task automatic model_step();
        logic lvl;
        logic rise;
        lvl  = trig_in ^ invert;
        rise = lvl && !m_prev;
        m_prev = rst_n ? lvl : 1'b1;
        if (!rst_n || disarm) begin
            m_mode = 0;
            m_left = '0;
        end else begin
            case (m_mode)
                0: m_mode = 1;
                1: if (rise) begin
                       m_mode = 2;
                       m_left = (hold_count == '0) ? 1 : hold_count;
                   end
                2: begin
                       m_left = m_left - 1;
                       if (m_left == '0) m_mode = auto_rearm ? 1 : 3;
                   end
                default: m_mode = 3;
            endcase
        end
        exp_out = (m_mode == 2);
    endtask

    // One clock: model, edge, then compare away from the edge.
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (trig_out !== exp_out) begin
            errors++;
            $display("FAIL %s: trig_out=%0b expected=%0b at %0t", tag, trig_out, exp_out, $time);
        end
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        // R1: reset state
        ticks(3, "R1");
        rst_n = 1'b1;
        ticks(2, "R1");
        disarm = 1'b0;
        ticks(3, "R9 arm after release");

        // R3 / R4: normal pulse of 5
        hold_count = 64'd5;
        trig_in = 1'b1;
        tick("R3");
        hold_count = 64'd1;            // R4: change during pulse ignored
        ticks(7, "R4");
        trig_in = 1'b0;
        ticks(2, "R8 spent");
        trig_in = 1'b1;
        ticks(4, "R8 ignored while spent");

        // Rearm by disarm pulse; R5 zero count
        disarm = 1'b1; tick("R8 disarm pulse");
        disarm = 1'b0; ticks(2, "R9 high level at release");
        trig_in = 1'b0; tick("R5");
        hold_count = '0;
        trig_in = 1'b1; ticks(3, "R5");

        // R2: inverted polarity, R7 auto rearm, R6 retrigger in hold
        disarm = 1'b1; invert = 1'b1; auto_rearm = 1'b1; tick("R2");
        disarm = 1'b0; ticks(2, "R2");
        hold_count = 64'd6;
        trig_in = 1'b0; tick("R2 falling edge fires");
        trig_in = 1'b1; tick("R6");
        trig_in = 1'b0; ticks(2, "R6 retrigger ignored");
        trig_in = 1'b1; ticks(4, "R6");
        trig_in = 1'b0; ticks(8, "R7 new edge after rearm");

        // R9: abort mid pulse; R10: upper word of count
        trig_in = 1'b1; tick("R9");
        trig_in = 1'b0; hold_count = 64'h1_0000_0000; tick("R10");
        ticks(300, "R10 upper word holds");
        disarm = 1'b1; tick("R9 abort");
        disarm = 1'b0; ticks(3, "R9");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 3 == 0) trig_in = ~trig_in;
            if ($urandom % 64 == 0) invert = ~invert;
            if ($urandom % 32 == 0) auto_rearm = ~auto_rearm;
            disarm = ($urandom % 150 == 0);
            if ($urandom % 4 == 0) hold_count = 64'($urandom % 10);
            tick("R4 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule